// File: doc/BRIEF.md
# Instruction Fetch Cache with Line Buffer and Inhibit

The block serves instruction longword fetches. A 4-longword line buffer sits between the fetch port and memory. In front of it, a 4-way set-associative cache of 16-byte lines can hold recent lines. A fetch that falls inside the buffered line is answered at once. Otherwise the cache is searched, when it is enabled. A miss refills the line buffer with four longwords through a request/acknowledge memory port. The refilled line is copied into a cache way only when caching is enabled and the access is not inhibited.

Address translation supplies an inhibit flag, and a region table lookup supplies a cacheable flag; either one can forbid caching. If the cache holds a line that is now inhibited, that line is dropped and the fetch is served through the line buffer. Each fetch reports a cost in clocks. An invalidate input empties the cache and the line buffer in one cycle.

Top module: `icache_lb`

## Requirements
- R1: A fetch whose address bits 31:4 equal the valid line-buffer line is answered with the buffered word (word index = address bits 3:2), cost 0, and no memory access.
- R2: With `cache_en` low, every line-buffer miss fetches 4 longwords and allocates nothing. A later fetch to a line that has left the buffer fetches it from memory again.
- R3: The cache tag is address bits 31:8 (default 16 sets) together with `fetch_super`. The same address fetched in the other mode misses.
- R4: A cache hit that is not inhibited returns the stored word with cost 1 and makes no memory access.
- R5: A cacheable miss allocates the lowest-numbered invalid way of set `addr[7:4]`.
- R6: Every non-inhibited cache hit increments a hit counter. When all 4 ways of the set are valid, the victim way is (counter >> 1) & 3.
- R7: An access is inhibited when `xlat_inhibit` is 1 or `region_cacheable` is 0. An inhibited miss fills only the line buffer.
- R8: A cache hit on an inhibited access invalidates that way and performs a 4-longword line-buffer fill instead.
- R9: A fill reports cost 4, or 0 when `exact_timing` was high at the request.
- R10: `invalidate_all` clears every cache valid bit and the line buffer in one cycle.
- R11: A fill issues 4 memory reads at line base + 0, 4, 8, 12 in that order. `mem_addr` holds steady until `mem_ack`. `fetch_valid` and `fetch_data` hold until the next accepted request.
- R12: After reset, `fetch_ready` is 1, `fetch_valid` is 0, `mem_req` is 0, and the cache and the line buffer are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request, taken when `fetch_ready` is high |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_super | input | 1 | Supervisor mode of the fetch |
| cache_en | input | 1 | Cache enable |
| xlat_inhibit | input | 1 | Cache inhibit from translation |
| region_cacheable | input | 1 | Region table says the address is cacheable |
| exact_timing | input | 1 | Exact memory timing: fill cost reported as 0 |
| invalidate_all | input | 1 | Clear cache and line buffer |
| fetch_ready | output | 1 | Block can take a request |
| fetch_valid | output | 1 | `fetch_data` and `fetch_cost` are valid |
| fetch_data | output | 32 | Fetched longword |
| fetch_cost | output | 3 | Clocks charged for the fetch |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory longword address |
| mem_ack | input | 1 | Memory data is valid |
| mem_data | input | 32 | Memory read data |

## Verification
Memory contents change after every fill, so a cached or buffered copy is stale against memory. A wrong valid bit, tag or victim therefore shows up at the ports on the next fetch to the affected line. It appears as either a data word from the wrong generation, an unexpected cost, or an unexpected 4-word fill. A lost hit count changes the victim only once a set is full, so random traffic over a few heavily shared sets is used to expose it within a handful of evictions. Every memory address is compared with the expected line base and word order at the moment it is acknowledged.

// File: rtl/icache_lb.sv
module icache_lb #(
  parameter int SETS = 16,
  parameter int CNTW = 8
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_req,
  input  logic [31:0] fetch_addr,
  input  logic        fetch_super,
  input  logic        cache_en,
  input  logic        xlat_inhibit,
  input  logic        region_cacheable,
  input  logic        exact_timing,
  input  logic        invalidate_all,
  output logic        fetch_ready,
  output logic        fetch_valid,
  output logic [31:0] fetch_data,
  output logic [2:0]  fetch_cost,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_data
);
  localparam int SB    = $clog2(SETS);
  localparam int IB    = SB + 4;
  localparam int TW    = 33 - IB;
  localparam int LINES = SETS * 4;
  localparam int XW    = SB + 2;

  logic [TW-1:0]    tag_q [LINES];
  logic [127:0]     dat_q [LINES];
  logic [LINES-1:0] vld_q;
  logic [31:0]      lb_q [4];
  logic [27:0]      lb_line, line_q;
  logic             lb_vld, busy, alloc_q, exact_q;
  logic [1:0]       lws_q, way_q, wcnt, last_q;
  logic [SB-1:0]    set_q;
  logic [TW-1:0]    tag_r;
  logic [CNTW-1:0]  hcnt;

  wire [SB-1:0] set_i     = fetch_addr[IB-1:4];
  wire [TW-1:0] tag_i     = {fetch_addr[31:IB], fetch_super};
  wire          inh_i     = xlat_inhibit | ~region_cacheable;
  wire          lb_hit    = lb_vld && (lb_line == fetch_addr[31:4]);
  wire          accept    = fetch_req && !busy;
  wire          fill_done = busy && mem_ack && (wcnt == 2'd3);

  logic       hit, found_free;
  logic [1:0] hway, vict;
  always_comb begin
    hit = 1'b0;
    hway = '0;
    for (int k = 0; k < 4; k++) begin
      if (!hit && vld_q[{set_i, last_q + 2'(k)}] &&
          tag_q[{set_i, last_q + 2'(k)}] == tag_i) begin
        hit  = 1'b1;
        hway = last_q + 2'(k);
      end
    end
    vict = hcnt[2:1];
    found_free = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (!found_free && !vld_q[{set_i, 2'(k)}]) begin
        found_free = 1'b1;
        vict = 2'(k);
      end
    end
  end

  wire [XW-1:0] hidx = {set_i, hway};
  wire [XW-1:0] aidx = {set_q, way_q};

  assign fetch_ready = !busy;
  assign mem_req     = busy;
  assign mem_addr    = {line_q, wcnt, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;  lb_vld <= 1'b0;  lb_line <= '0;  vld_q <= '0;
      fetch_valid <= 1'b0;  fetch_data <= '0;  fetch_cost <= '0;
      line_q <= '0;  lws_q <= '0;  way_q <= '0;  wcnt <= '0;  last_q <= '0;
      set_q <= '0;  tag_r <= '0;  hcnt <= '0;  alloc_q <= 1'b0;  exact_q <= 1'b0;
    end else begin
      if (accept) begin
        fetch_valid <= 1'b0;
        line_q  <= fetch_addr[31:4];
        lws_q   <= fetch_addr[3:2];
        set_q   <= set_i;
        tag_r   <= tag_i;
        way_q   <= vict;
        exact_q <= exact_timing;
        alloc_q <= cache_en && !inh_i;
        wcnt    <= '0;
        if (lb_hit) begin
          fetch_valid <= 1'b1;
          fetch_data  <= lb_q[fetch_addr[3:2]];
          fetch_cost  <= 3'd0;
        end else if (cache_en && hit && !inh_i) begin
          fetch_valid <= 1'b1;
          fetch_data  <= dat_q[hidx][{fetch_addr[3:2], 5'b0} +: 32];
          fetch_cost  <= 3'd1;
          last_q      <= hway;
          hcnt        <= hcnt + CNTW'(1);
        end else begin
          busy   <= 1'b1;
          lb_vld <= 1'b0;
          if (cache_en && hit) vld_q[hidx] <= 1'b0;
        end
      end
      if (busy && mem_ack) begin
        wcnt <= wcnt + 2'd1;
        if (wcnt == 2'd3) begin
          busy        <= 1'b0;
          lb_vld      <= 1'b1;
          lb_line     <= line_q;
          fetch_valid <= 1'b1;
          fetch_data  <= (lws_q == 2'd3) ? mem_data : lb_q[lws_q];
          fetch_cost  <= exact_q ? 3'd0 : 3'd4;
          if (alloc_q) vld_q[aidx] <= 1'b1;
        end
      end
      if (invalidate_all) begin
        vld_q  <= '0;
        lb_vld <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy && mem_ack) lb_q[wcnt] <= mem_data;
    if (fill_done && alloc_q) begin
      tag_q[aidx] <= tag_r;
      dat_q[aidx] <= {mem_data, lb_q[2], lb_q[1], lb_q[0]};
    end
  end

  p_lbhit_nomem_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && lb_hit |=> !mem_req && fetch_valid && fetch_cost == 3'd0);
  p_hitcnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept) && fetch_valid && fetch_cost == 3'd1 |-> hcnt == $past(hcnt) + CNTW'(1));
  p_fill_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> fetch_valid && !mem_req);
  p_inval_r10: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate_all |=> vld_q == '0 && !lb_vld);
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !accept |=> fetch_valid && $stable(fetch_data) && $stable(fetch_cost));
endmodule

// File: tb/tb_icache_lb.sv
`timescale 1ns/1ps
module tb_icache_lb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic fetch_req = 1'b0, fetch_super = 1'b0, cache_en = 1'b0, xlat_inhibit = 1'b0;
  logic region_cacheable = 1'b1, exact_timing = 1'b0, invalidate_all = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic fetch_ready, fetch_valid, mem_req;
  logic [31:0] fetch_data, mem_addr;
  logic [2:0] fetch_cost;
  logic mem_ack = 1'b0;
  logic [31:0] mem_data = '0;

  icache_lb dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_super(fetch_super), .cache_en(cache_en), .xlat_inhibit(xlat_inhibit),
    .region_cacheable(region_cacheable), .exact_timing(exact_timing),
    .invalidate_all(invalidate_all), .fetch_ready(fetch_ready), .fetch_valid(fetch_valid),
    .fetch_data(fetch_data), .fetch_cost(fetch_cost), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data));

  int epoch = 0;
  function automatic logic [31:0] memf(input logic [31:0] a, input int e);
    return {a[31:2], 2'b00} ^ (32'(e) << 24) ^ 32'h00A5_0000;
  endfunction

  always @(posedge clk) begin
    mem_ack  <= mem_req && !mem_ack;
    mem_data <= memf(mem_addr, epoch);
  end

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  logic [31:0] fill_base = '0;
  int fill_k = 0;
  always @(negedge clk)
    if (rst_n && mem_req && mem_ack) begin
      chk(mem_addr == fill_base + 32'(4 * fill_k), "R11 fill address", mem_addr, fill_base + 32'(4 * fill_k));
      fill_k++;
    end

  bit          rv [16][4];
  logic [24:0] rt [16][4];
  int          re [16][4];
  bit          rlbv = 0;
  logic [27:0] rlbl = '0;
  int          rlbe = 0;
  int          rh = 0;

  task automatic do_fetch(input logic [31:0] a, input bit sup, input bit en, input bit xi,
                          input bit rc, input bit ex, input string rq);
    logic [31:0] d;
    int c, f, s, hw;
    bit hit, inh, fr;
    logic [24:0] tg;
    s = int'(a[7:4]);
    tg = {a[31:8], sup};
    inh = xi || !rc;
    hit = 0; hw = 0;
    for (int w = 0; w < 4; w++)
      if (!hit && rv[s][w] && rt[s][w] == tg) begin hit = 1; hw = w; end
    if (rlbv && rlbl == a[31:4]) begin
      d = memf(a, rlbe); c = 0; f = 0;
    end else if (en && hit && !inh) begin
      d = memf(a, re[s][hw]); c = 1; f = 0; rh++;
    end else begin
      if (en && hit) rv[s][hw] = 0;
      d = memf(a, epoch); c = ex ? 0 : 4; f = 4;
      rlbv = 1; rlbl = a[31:4]; rlbe = epoch;
      if (en && !inh) begin
        fr = 0; hw = (rh >> 1) & 3;
        for (int w = 0; w < 4; w++)
          if (!fr && !rv[s][w]) begin fr = 1; hw = w; end
        rv[s][hw] = 1; rt[s][hw] = tg; re[s][hw] = epoch;
      end
    end
    while (!fetch_ready) @(negedge clk);
    fill_base = {a[31:4], 4'b0};
    fill_k = 0;
    fetch_addr = a; fetch_super = sup; cache_en = en; xlat_inhibit = xi;
    region_cacheable = rc; exact_timing = ex; fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0;
    while (!fetch_valid) @(negedge clk);
    chk(fetch_data == d, {rq, " data"}, fetch_data, d);
    chk(32'(fetch_cost) == 32'(c), {rq, " cost"}, 32'(fetch_cost), 32'(c));
    chk(fill_k == f, {rq, " memory reads"}, 32'(fill_k), 32'(f));
    if (f == 4) epoch++;
  endtask

  task automatic inval();
    @(negedge clk);
    invalidate_all = 1'b1;
    @(negedge clk);
    invalidate_all = 1'b0;
    for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) rv[s][w] = 0;
    rlbv = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] held;
    for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) begin rv[s][w] = 0; rt[s][w] = '0; re[s][w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_ready == 1'b1, "R12 ready", 32'(fetch_ready), 1);
    chk(fetch_valid == 1'b0, "R12 valid", 32'(fetch_valid), 0);
    chk(mem_req == 1'b0, "R12 mem_req", 32'(mem_req), 0);
    do_fetch(32'h0000_1004, 0, 1, 0, 1, 0, "R12 empty after reset");

    do_fetch(32'h0000_1000, 0, 1, 0, 1, 0, "R1");
    do_fetch(32'h0000_1100, 0, 1, 0, 1, 0, "R5");
    do_fetch(32'h0000_1008, 0, 1, 0, 1, 0, "R4");
    held = fetch_data;
    repeat (3) @(negedge clk);
    chk(fetch_valid && fetch_data == held, "R11 hold", fetch_data, held);
    do_fetch(32'h0000_1000, 1, 1, 0, 1, 0, "R3");
    do_fetch(32'h0000_1200, 0, 1, 0, 1, 1, "R9");
    do_fetch(32'h0000_100C, 0, 1, 0, 1, 0, "R4");
    do_fetch(32'h0000_1104, 0, 1, 0, 1, 0, "R4");
    do_fetch(32'h0000_1300, 0, 1, 0, 1, 0, "R6");
    do_fetch(32'h0000_1000, 0, 1, 0, 1, 0, "R6");
    do_fetch(32'h0000_1100, 0, 1, 0, 1, 0, "R6");
    do_fetch(32'h0000_1200, 0, 1, 0, 1, 0, "R6");

    do_fetch(32'h0000_2010, 0, 0, 0, 1, 0, "R2");
    do_fetch(32'h0000_2020, 0, 0, 0, 1, 0, "R2");
    do_fetch(32'h0000_2010, 0, 0, 0, 1, 0, "R2");

    do_fetch(32'h0000_3010, 0, 1, 1, 1, 0, "R7");
    do_fetch(32'h0000_3020, 0, 1, 0, 1, 0, "R7");
    do_fetch(32'h0000_3010, 0, 1, 0, 1, 0, "R7");
    do_fetch(32'h0000_3030, 0, 1, 0, 0, 0, "R7");
    do_fetch(32'h0000_3020, 0, 1, 0, 1, 0, "R4");
    do_fetch(32'h0000_3030, 0, 1, 0, 1, 0, "R7");

    do_fetch(32'h0000_3040, 0, 1, 0, 1, 0, "R8");
    do_fetch(32'h0000_3024, 0, 1, 1, 1, 0, "R8");
    do_fetch(32'h0000_3050, 0, 1, 0, 1, 0, "R8");
    do_fetch(32'h0000_3020, 0, 1, 0, 1, 0, "R8");

    inval();
    do_fetch(32'h0000_3040, 0, 1, 0, 1, 0, "R10");
    inval();
    do_fetch(32'h0000_3044, 0, 1, 0, 1, 0, "R10");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = 32'h0001_0000 | (32'($urandom % 6) << 8) | (32'($urandom % 2) << 4) | (32'($urandom % 4) << 2);
      do_fetch(a, ($urandom % 4) == 0, ($urandom % 8) != 0, ($urandom % 10) == 0,
               ($urandom % 10) != 0, ($urandom % 3) == 0, "R6 random");
      if (i % 97 == 96) inval();
    end

    summary();
    $finish;
  end
endmodule